// File: doc/BRIEF.md
# Protection entry address checker

This block decides whether a single memory access is permitted. It compares the access address with sixteen software-programmed protection entries, each with its own start address, page size and permission bits. It then applies a small set of fixed rules for the system-register space and the on-chip L1 space. A request strobe starts one evaluation. One cycle later the block returns the verdict:

- an exception with a result code,
- a hardware-error strobe, or
- silence, meaning the access is allowed.

When an exception is raised, the block also presents the values to be loaded into the fault status and fault address registers of the side that faulted. A data-side fault additionally presents the program counter and the privilege flag for the instruction-side fault registers. The block does not dispatch exceptions, handle caches or provide register access. The entry registers and the enable bit arrive as plain inputs.

Top module: `prot_entry_checker`

## Requirements
- R1: Only entries whose valid bit (attribute bit 0) is 1 take part in matching. An entry covers the range start ≤ address < start + span. The span is set by attribute bits 17:16: 0 gives 1 KB, 1 gives 4 KB, 2 gives 1 MB and 3 gives 4 MB. When the checker is enabled, an access that hits no entry and is not resolved by a fixed rule is a miss, with result index 0.
- R2: Each covering entry sets its own bit in a 16-bit hit mask. Two or more covering entries give result index 2, whatever their permissions are.
- R3: A write with exactly one covering entry is a protection violation (index 1) in either of two cases: in user mode when attribute bit 3 is clear, or in supervisor mode when attribute bit 4 is clear.
- R4: A write to an entry with bit 12 set, bit 14 clear and bit 7 clear is a protection violation (index 1), even when the write permission bits allow it.
- R5: A user-mode read needs attribute bit 2, or it is a protection violation (index 1). A supervisor read needs no permission bit.
- R6: When the enable input is 0, the entries are ignored. The access counts as one hit, the hit mask reported in a fault is 0, and only the fixed rules apply.
- R7: An access whose address is not a multiple of 2^size_log2 bytes gives result index 3. An entry-based violation or a multiple hit takes priority over this.
- R8: At or above 0xFFC00000, an instruction fetch is a miss (index 0). A data access there from user mode, or from the second address generator, is a protection violation (index 1). A supervisor data access from the first generator is allowed, whether or not any entry covers it.
- R9: In 0xFF000000–0xFFBFFFFF, an instruction fetch is allowed only inside 0xFFA00000–0xFFAFFFFF and is a protection violation elsewhere. A data access inside 0xFFA00000–0xFFAFFFFF raises the hardware-error strobe and no exception. A data access elsewhere in that range is allowed.
- R10: On an exception, the fault status word presents the following, with all other bits 0:
  - bit 19: the miss flag (index 0)
  - bit 18: the second-generator flag
  - bit 17: the supervisor flag
  - bit 16: the write flag
  - bits 15:0: the hit mask

  The fault address equals the access address.
- R11: A data-side exception also asserts the PC-log strobe, with the PC as address and a status word that has only bit 17 (supervisor) possibly set. An instruction-side exception does not assert this strobe.
- R12: The response strobe is asserted exactly one cycle after each request. The exception, hardware-error and log strobes are asserted only on that cycle. The exception code is {instruction flag, 0, index[1:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Start one evaluation |
| req_addr | input | 32 | Access address |
| req_size_log2 | input | 2 | Log2 of the access size in bytes |
| req_write | input | 1 | Access is a write |
| req_instr | input | 1 | Access is an instruction fetch |
| req_supv | input | 1 | Supervisor mode |
| req_agen2 | input | 1 | Issued by the second address generator |
| req_pc | input | 32 | Program counter of the access |
| prot_en | input | 1 | Entry checking enabled |
| ent_start | input | 32*NUM_ENT | Entry start addresses, entry i at bits 32i+31:32i |
| ent_attr | input | 32*NUM_ENT | Entry attribute words, same packing |
| rsp_valid | output | 1 | Result available |
| exc_valid | output | 1 | Exception raised |
| exc_code | output | 4 | Exception code |
| hw_err | output | 1 | Hardware-error strobe |
| flt_we | output | 1 | Load fault status and address of the faulting side |
| flt_status | output | 32 | Fault status word |
| flt_addr | output | 32 | Fault address |
| pc_we | output | 1 | Load instruction-side fault registers on a data fault |
| pc_status | output | 32 | Instruction-side status word |
| pc_addr | output | 32 | Instruction-side fault address (PC) |

## Verification
The hardest outcomes to reach are the overlapping cases: a multiple hit that coincides with a permission violation, and an entry violation on a misaligned address. In both, one rule must take priority over another. Directed cases program entries that overlap on purpose and aim accesses at their shared part. The random phase sets entry starts within a few 64 KB windows, and those windows include the system and L1 spaces. Accesses land in the same windows, so multiple hits, violations and fixed-region rules all interact, and a reference function checks the combined outcome.

// File: rtl/prot_entry_checker.sv
module prot_entry_checker #(
  parameter int          NUM_ENT    = 16,
  parameter logic [31:0] SYS_BASE   = 32'hFFC0_0000,
  parameter logic [7:0]  L1_TOP     = 8'hFF,
  parameter logic [11:0] L1_EXEC_MB = 12'hFFA
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [31:0]             req_addr,
  input  logic [1:0]              req_size_log2,
  input  logic                    req_write,
  input  logic                    req_instr,
  input  logic                    req_supv,
  input  logic                    req_agen2,
  input  logic [31:0]             req_pc,
  input  logic                    prot_en,
  input  logic [32*NUM_ENT-1:0]   ent_start,
  input  logic [32*NUM_ENT-1:0]   ent_attr,
  output logic                    rsp_valid,
  output logic                    exc_valid,
  output logic [3:0]              exc_code,
  output logic                    hw_err,
  output logic                    flt_we,
  output logic [31:0]             flt_status,
  output logic [31:0]             flt_addr,
  output logic                    pc_we,
  output logic [31:0]             pc_status,
  output logic [31:0]             pc_addr
);
  localparam int B_VALID = 0;
  localparam int B_URD   = 2;
  localparam int B_UWR   = 3;
  localparam int B_SWR   = 4;
  localparam int B_DIRTY = 7;
  localparam int B_L1C   = 12;
  localparam int B_WT    = 14;
  localparam int B_PGLO  = 16;

  logic [NUM_ENT-1:0] hit, viol;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    logic [31:0] st, at;
    logic [32:0] lim;
    logic [32:0] span;
    assign st = ent_start[g*32 +: 32];
    assign at = ent_attr[g*32 +: 32];
    always_comb begin
      case (at[B_PGLO +: 2])
        2'd0:    span = 33'h0000_0400;
        2'd1:    span = 33'h0000_1000;
        2'd2:    span = 33'h0010_0000;
        default: span = 33'h0040_0000;
      endcase
    end
    assign lim     = {1'b0, st} + span;
    assign hit[g]  = at[B_VALID] && (req_addr >= st) && ({1'b0, req_addr} < lim);
    assign viol[g] = hit[g] && (req_write
                     ? ((!req_supv && !at[B_UWR]) || (req_supv && !at[B_SWR]) ||
                        (at[B_L1C] && !at[B_WT] && !at[B_DIRTY]))
                     : (!req_supv && !at[B_URD]));
  end

  logic        many, one, misal, in_sys, in_l1, exec_mb;
  logic        fault, hwe;
  logic [1:0]  idx;
  logic [15:0] mask16;
  logic [31:0] amask;

  assign many    = prot_en && |(hit & (hit - 1'b1));
  assign one     = !prot_en || ((|hit) && !many);
  assign amask   = (32'd1 << req_size_log2) - 32'd1;
  assign misal   = |(req_addr & amask);
  assign in_sys  = req_addr >= SYS_BASE;
  assign in_l1   = req_addr[31:24] == L1_TOP;
  assign exec_mb = req_addr[31:20] == L1_EXEC_MB;

  always_comb begin
    mask16 = '0;
    if (prot_en) mask16[NUM_ENT-1:0] = hit;
  end

  always_comb begin
    fault = 1'b0;
    hwe   = 1'b0;
    idx   = 2'd0;
    if (prot_en && (many || |viol)) begin
      fault = 1'b1;
      idx   = many ? 2'd2 : 2'd1;
    end else if (misal) begin
      fault = 1'b1;
      idx   = 2'd3;
    end else if (in_sys) begin
      if (req_instr) begin
        fault = 1'b1;
      end else if (!req_supv || req_agen2) begin
        fault = 1'b1;
        idx   = 2'd1;
      end
    end else if (in_l1) begin
      if (req_instr && !exec_mb) begin
        fault = 1'b1;
        idx   = 2'd1;
      end else if (!req_instr && exec_mb) begin
        hwe = 1'b1;
      end
    end else if (!one) begin
      fault = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      exc_valid  <= 1'b0;
      hw_err     <= 1'b0;
      flt_we     <= 1'b0;
      pc_we      <= 1'b0;
      exc_code   <= '0;
      flt_status <= '0;
      flt_addr   <= '0;
      pc_status  <= '0;
      pc_addr    <= '0;
    end else begin
      rsp_valid <= req_valid;
      exc_valid <= req_valid && fault;
      hw_err    <= req_valid && hwe;
      flt_we    <= req_valid && fault;
      pc_we     <= req_valid && fault && !req_instr;
      if (req_valid) begin
        exc_code   <= {req_instr, 1'b0, idx};
        flt_status <= {12'd0, fault && (idx == 2'd0), req_agen2, req_supv, req_write, mask16};
        flt_addr   <= req_addr;
        pc_status  <= {14'd0, req_supv, 17'd0};
        pc_addr    <= req_pc;
      end
    end
  end

  // R12
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R12
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && !exc_valid && !hw_err && !pc_we);
  // R9
  hwerr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_err |-> !exc_valid);
  // R11
  pc_log_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |-> flt_we && !exc_code[3]);
  // R2
  multi_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_code[1:0] == 2'd2) |-> $countones(flt_status[15:0]) >= 2);
  // R10
  miss_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flt_we |-> exc_valid && (flt_status[19] == (exc_code[1:0] == 2'd0)));
endmodule

// File: tb/tb_prot_entry_checker.sv
module tb_prot_entry_checker;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size_log2 = '0;
  logic        req_write = 1'b0, req_instr = 1'b0, req_supv = 1'b0, req_agen2 = 1'b0;
  logic [31:0] req_pc = '0;
  logic        prot_en = 1'b0;
  logic [31:0] st [N];
  logic [31:0] at [N];
  logic [32*N-1:0] ent_start, ent_attr;
  logic        rsp_valid, exc_valid, hw_err, flt_we, pc_we;
  logic [3:0]  exc_code;
  logic [31:0] flt_status, flt_addr, pc_status, pc_addr;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      ent_start[i*32 +: 32] = st[i];
      ent_attr[i*32 +: 32]  = at[i];
    end
  end

  prot_entry_checker dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size_log2(req_size_log2), .req_write(req_write), .req_instr(req_instr),
    .req_supv(req_supv), .req_agen2(req_agen2), .req_pc(req_pc), .prot_en(prot_en),
    .ent_start(ent_start), .ent_attr(ent_attr), .rsp_valid(rsp_valid),
    .exc_valid(exc_valid), .exc_code(exc_code), .hw_err(hw_err), .flt_we(flt_we),
    .flt_status(flt_status), .flt_addr(flt_addr), .pc_we(pc_we),
    .pc_status(pc_status), .pc_addr(pc_addr));

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic void ref_model(input logic [31:0] a, input logic [1:0] szl,
      input bit wr, input bit ins, input bit sv, input bit g2, input bit en,
      output bit ex, output logic [3:0] code, output bit he, output logic [31:0] stat);
    int nh = 0;
    bit pv = 0;
    int r = 0;
    logic [15:0] m = '0;
    logic [63:0] lo, span;
    ex = 0; he = 0;
    if (en) begin
      for (int i = 0; i < N; i++) begin
        if (at[i][0]) begin
          lo = {32'd0, st[i]};
          case (at[i][17:16])
            2'd0: span = 64'h400;
            2'd1: span = 64'h1000;
            2'd2: span = 64'h10_0000;
            default: span = 64'h40_0000;
          endcase
          if ({32'd0, a} >= lo && {32'd0, a} < lo + span) begin
            nh++;
            m[i] = 1'b1;
            if (wr) begin
              if (!sv && !at[i][3]) pv = 1;
              if (sv && !at[i][4]) pv = 1;
              if (at[i][12] && !at[i][14] && !at[i][7]) pv = 1;
            end else if (!sv && !at[i][2]) pv = 1;
          end
        end
      end
    end
    if (en && (pv || nh >= 2)) begin
      ex = 1; r = (nh >= 2) ? 2 : 1;
    end else if ((a % (32'd1 << szl)) != 0) begin
      ex = 1; r = 3;
    end else if (a >= 32'hFFC0_0000) begin
      if (ins) begin ex = 1; r = 0; end
      else if (!sv || g2) begin ex = 1; r = 1; end
    end else if (a[31:24] == 8'hFF) begin
      if (ins) begin
        if (a[31:20] != 12'hFFA) begin ex = 1; r = 1; end
      end else if (a[31:20] == 12'hFFA) he = 1;
    end else if ((en ? nh : 1) != 1) begin
      ex = 1; r = 0;
    end
    code = {ins, 1'b0, 2'(r)};
    stat = {12'd0, ex && (r == 0), g2, sv, wr, m};
  endfunction

  task automatic access(string tag, logic [31:0] a, logic [1:0] szl, bit wr, bit ins,
                        bit sv, bit g2, bit en);
    bit ex, he;
    logic [3:0] code;
    logic [31:0] stat, pc;
    pc = $urandom;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size_log2 = szl; req_write = wr;
    req_instr = ins; req_supv = sv; req_agen2 = g2; prot_en = en; req_pc = pc;
    ref_model(a, szl, wr, ins, sv, g2, en, ex, code, he, stat);
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R12 rsp"}, 32'(rsp_valid), 32'd1);
    chk({tag, " exc"}, 32'(exc_valid), 32'(ex));
    chk({tag, " R9 hwerr"}, 32'(hw_err), 32'(he));
    if (ex) begin
      chk({tag, " R12 code"}, 32'(exc_code), 32'(code));
      chk({tag, " R10 status"}, flt_status, stat);
      chk({tag, " R10 addr"}, flt_addr, a);
      chk({tag, " R11 pcwe"}, 32'(pc_we), 32'(!ins));
      if (!ins) begin
        chk({tag, " R11 pc"}, pc_addr, pc);
        chk({tag, " R11 pcst"}, pc_status, {14'd0, sv, 17'd0});
      end
    end else begin
      chk({tag, " R12 fltwe"}, 32'(flt_we), 32'd0);
    end
  endtask

  task automatic clear_entries();
    for (int i = 0; i < N; i++) begin st[i] = '0; at[i] = '0; end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] zones [5];
    void'($urandom(32'd4242));
    zones[0] = 32'h0010_0000; zones[1] = 32'hFFA0_0000; zones[2] = 32'hFF80_0000;
    zones[3] = 32'hFFC0_0000; zones[4] = 32'hFFFF_0000;
    clear_entries();
    repeat (3) @(negedge clk);
    chk("R12 reset rsp", 32'(rsp_valid), 32'd0);
    chk("R12 reset exc", 32'(exc_valid), 32'd0);
    chk("R12 reset hw", 32'(hw_err), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 idle pcwe", 32'(pc_we), 32'd0);

    st[0] = 32'h0010_0000; at[0] = 32'h0001_001D;
    st[1] = 32'h0020_0000; at[1] = 32'h0002_001D;
    access("R1 inside 4K", 32'h0010_0FFC, 2'd2, 0, 0, 0, 0, 1);
    access("R1 past 4K", 32'h0010_1000, 2'd2, 0, 0, 0, 0, 1);
    access("R1 inside 1M", 32'h002F_FFF0, 2'd2, 0, 0, 0, 0, 1);
    at[1][0] = 1'b0;
    access("R1 invalid ent", 32'h0020_0000, 2'd2, 0, 0, 1, 0, 1);
    st[2] = 32'h0010_0800; at[2] = 32'h0000_001D;
    access("R2 overlap", 32'h0010_0900, 2'd2, 0, 0, 0, 0, 1);
    st[3] = 32'h0030_0000; at[3] = 32'h0001_0015;
    access("R3 user wr", 32'h0030_0010, 2'd2, 1, 0, 0, 0, 1);
    at[3] = 32'h0001_000D;
    access("R3 supv wr", 32'h0030_0010, 2'd2, 1, 0, 1, 0, 1);
    at[3] = 32'h0001_101D;
    access("R4 clean cache", 32'h0030_0010, 2'd2, 1, 0, 1, 0, 1);
    at[3] = 32'h0001_509D;
    access("R4 wt ok", 32'h0030_0010, 2'd2, 1, 0, 0, 0, 1);
    at[3] = 32'h0001_0019;
    access("R5 user rd", 32'h0030_0020, 2'd2, 0, 0, 0, 0, 1);
    access("R5 supv rd", 32'h0030_0020, 2'd2, 0, 0, 1, 0, 1);
    access("R6 disabled", 32'h0050_0000, 2'd2, 1, 0, 0, 0, 0);
    access("R6 disabled sys", 32'hFFC0_0000, 2'd2, 0, 1, 1, 0, 0);
    access("R7 misal", 32'h0010_0002, 2'd2, 0, 0, 0, 0, 1);
    access("R7 prio", 32'h0010_0902, 2'd2, 0, 0, 0, 0, 1);
    access("R8 sys fetch", 32'hFFC0_1000, 2'd1, 0, 1, 1, 0, 1);
    access("R8 sys user", 32'hFFC0_1000, 2'd2, 0, 0, 0, 0, 1);
    access("R8 sys agen2", 32'hFFC0_1000, 2'd2, 1, 0, 1, 1, 1);
    access("R8 sys ok", 32'hFFE0_1000, 2'd2, 0, 0, 1, 0, 1);
    access("R9 exec ok", 32'hFFA0_0100, 2'd1, 0, 1, 0, 0, 1);
    access("R9 exec bad", 32'hFF80_0100, 2'd1, 0, 1, 1, 0, 1);
    access("R9 data hwerr", 32'hFFA1_0000, 2'd2, 0, 0, 1, 0, 1);
    access("R9 data ok", 32'hFF80_0100, 2'd2, 1, 0, 0, 0, 0);

    for (int k = 0; k < 3000; k++) begin
      if (k % 50 == 0) begin
        for (int i = 0; i < N; i++) begin
          st[i] = zones[$urandom % 5] + (($urandom & 32'h3F) << 10);
          at[i] = ($urandom & 32'h0003_509C) | 32'(($urandom % 3) != 0);
        end
      end
      access("R1 random", zones[$urandom % 5] + ($urandom & 32'hFFFF), 2'($urandom),
             1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
             ($urandom % 6) != 0);
    end
    finish_run();
  end
endmodule